// File: doc/BRIEF.md
# Manchester Frame Sync Monitor

This block watches the decoded bit streams of several independent Manchester decoder lanes and reports for each lane whether frame synchronisation is held. Every frame carries one sync bit at a fixed bit index, and that bit must take the opposite value from the sync bit of the frame before. The monitor decides that a lane is synchronised once it has seen a long enough run of correctly alternating frames.

While a lane is synchronised, a frame whose sync bit repeats the previous one is a sync-bit error. Errors are counted in a window of frames that opens on the first error. Sync is dropped when enough errors land inside that window. A window that expires is not reset at once: the count is held and restarts only when the next error arrives. The current error count of each lane is brought out for debug.

Each lane has a bit strobe with its decoded data bit and a frame-boundary strobe from the upstream decoder. Clock recovery and payload extraction are done elsewhere.

Top module: `frame_sync_monitor`

## Requirements
- R1: During and after reset, every bit of `syncOk` is 0 and every field of `errCount` is 0.
- R2: The sync bit of a frame is the data bit on the bit strobe with zero-based index `SYNC_POS` (default 2), counted from the previous `frameMark` or from reset. `frameMark` ends the frame, and a bit strobe in the same cycle as `frameMark` is discarded.
- R3: An unsynchronised lane sets `syncOk` after a reference frame followed by `ACQ_FRAMES` (default 4) consecutive frames whose sync bit alternates. `syncOk` rises in the cycle after the `frameMark` of the last of these frames.
- R4: During acquisition, a frame whose sync bit does not alternate resets the run, and that frame becomes the new reference.
- R5: A frame ended by `frameMark` before its sync bit arrived changes no state: the sync status, the error count and the reference bit all stay as they were.
- R6: While synchronised, a sync-bit error with no open window opens a window in which that frame is frame 1, and sets the count to 1. A later error inside the window increments the count. `errCount` updates in the cycle after the `frameMark`.
- R7: An error that brings the count to `LOSS_ERRS` (default 3) within frames 1 to `WINDOW` (default 10) of the window clears `syncOk` and resets `errCount` to 0.
- R8: Once the window has passed frame `WINDOW`, the count is held until the next error. That error opens a new window with the count set to 1.
- R9: After a loss of sync, the lane re-acquires as in R3, starting with a fresh reference frame.
- R10: Lanes are independent. Stimulus on one lane never changes the outputs of another.
- R11: `errCount` of a lane is 0 whenever its `syncOk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bitValid | input | LANES | Per-lane decoded-bit strobe |
| bitData | input | LANES | Per-lane decoded bit, sampled when `bitValid` is high |
| frameMark | input | LANES | Per-lane frame-boundary strobe |
| syncOk | output | LANES | Per-lane synchronisation status |
| errCount | output | LANES*ERR_W | Per-lane sync-bit error count (debug), lane i at bits [i*ERR_W +: ERR_W] |

## Verification
A wrong reference bit or a wrong run counter shows up as `syncOk` rising one frame early or one frame late. This is visible in the cycle after the deciding `frameMark`. A window index that is off by one moves the loss of sync or the lazy restart across the frame-10 boundary, so the directed cases place errors at frames 10 and 11 and read `errCount` right after each frame. A stray bit counted at a frame boundary shifts the sync-bit position, and on the very next frame this turns a good frame into an error that `errCount` reports.

// File: rtl/frame_sync_pkg.sv
package frame_sync_pkg;

  typedef enum logic {
    ST_ACQUIRE = 1'b0,
    ST_LOCKED  = 1'b1
  } lockState_t;

  // datapath -> control, one per lane
  typedef struct packed {
    logic frameDone;   // frame closed with a captured sync bit
    logic alternates;  // sync bit differs from the reference bit
  } frameInfo_t;

  // control -> datapath, one per lane
  typedef struct packed {
    logic clearRef;    // forget the reference bit at this frame end
  } laneCtrl_t;

endpackage

// File: rtl/fsm_lane_datapath.sv
module fsm_lane_datapath
  import frame_sync_pkg::*;
#(
  parameter int SYNC_POS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bitValid,
  input  logic       bitData,
  input  logic       frameMark,
  input  laneCtrl_t  ctrl,
  output frameInfo_t info
);
  localparam int CNT_W = $clog2(SYNC_POS + 2);
  localparam logic [CNT_W-1:0] POS = CNT_W'(SYNC_POS);

  logic [CNT_W-1:0] bitIdx;
  logic sawSync;
  logic curBit;
  logic prevBit;
  logic hasPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitIdx  <= '0;
      sawSync <= 1'b0;
      curBit  <= 1'b0;
      prevBit <= 1'b0;
      hasPrev <= 1'b0;
    end else if (frameMark) begin
      // bit strobe in this cycle is dropped; next frame counts from 0
      bitIdx  <= '0;
      sawSync <= 1'b0;
      if (sawSync) begin
        prevBit <= curBit;
        hasPrev <= !ctrl.clearRef;
      end
    end else if (bitValid && (bitIdx <= POS)) begin
      bitIdx <= bitIdx + 1'b1;
      if (bitIdx == POS) begin
        curBit  <= bitData;
        sawSync <= 1'b1;
      end
    end
  end

  assign info.frameDone  = frameMark & sawSync;
  assign info.alternates = hasPrev & (curBit ^ prevBit);

endmodule

// File: rtl/fsm_lane_control.sv
module fsm_lane_control
  import frame_sync_pkg::*;
#(
  parameter int ACQ_FRAMES = 4,
  parameter int WINDOW     = 10,
  parameter int LOSS_ERRS  = 3,
  parameter int ERR_W      = $clog2(LOSS_ERRS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  frameInfo_t       info,
  output laneCtrl_t        ctrl,
  output logic             synced,
  output logic [ERR_W-1:0] errCount
);
  localparam int RUN_W = $clog2(ACQ_FRAMES + 1);
  localparam int WIN_W = $clog2(WINDOW + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(ACQ_FRAMES - 1);
  localparam logic [WIN_W-1:0] WIN_MAX  = WIN_W'(WINDOW);
  localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(LOSS_ERRS - 1);

  lockState_t       state, stateNext;
  logic [RUN_W-1:0] runCnt, runNext;
  logic [WIN_W-1:0] winIdx, winNext;
  logic             winOpen, winOpenNext;
  logic [ERR_W-1:0] errCnt, errNext;
  logic             frameErr;
  logic             inWindow;

  assign frameErr = !info.alternates;
  assign inWindow = winOpen && (winIdx != WIN_MAX);

  always_comb begin
    stateNext     = state;
    runNext       = runCnt;
    winNext       = winIdx;
    winOpenNext   = winOpen;
    errNext       = errCnt;
    ctrl.clearRef = 1'b0;
    if (info.frameDone) begin
      unique case (state)
        ST_ACQUIRE: begin
          if (info.alternates) begin
            if (runCnt == RUN_LAST) begin
              stateNext = ST_LOCKED;
              runNext   = '0;
            end else begin
              runNext = runCnt + 1'b1;
            end
          end else begin
            runNext = '0;  // this frame is the new reference
          end
        end
        ST_LOCKED: begin
          if (inWindow) begin
            winNext = winIdx + 1'b1;
            if (frameErr) begin
              if (errCnt == ERR_LAST) begin
                stateNext     = ST_ACQUIRE;
                ctrl.clearRef = 1'b1;
                winOpenNext   = 1'b0;
                winNext       = '0;
                errNext       = '0;
                runNext       = '0;
              end else begin
                errNext = errCnt + 1'b1;
              end
            end
          end else if (frameErr) begin
            winOpenNext = 1'b1;
            winNext     = WIN_W'(1);
            errNext     = ERR_W'(1);
          end else begin
            winOpenNext = 1'b0;  // count held until the next error
          end
        end
        default: stateNext = ST_ACQUIRE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_ACQUIRE;
      runCnt  <= '0;
      winIdx  <= '0;
      winOpen <= 1'b0;
      errCnt  <= '0;
    end else begin
      state   <= stateNext;
      runCnt  <= runNext;
      winIdx  <= winNext;
      winOpen <= winOpenNext;
      errCnt  <= errNext;
    end
  end

  assign synced   = (state == ST_LOCKED);
  assign errCount = errCnt;

endmodule

// File: rtl/frame_sync_monitor.sv
module frame_sync_monitor
  import frame_sync_pkg::*;
#(
  parameter int LANES      = 3,
  parameter int SYNC_POS   = 2,
  parameter int ACQ_FRAMES = 4,
  parameter int WINDOW     = 10,
  parameter int LOSS_ERRS  = 3,
  parameter int ERR_W      = $clog2(LOSS_ERRS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       bitValid,
  input  logic [LANES-1:0]       bitData,
  input  logic [LANES-1:0]       frameMark,
  output logic [LANES-1:0]       syncOk,
  output logic [LANES*ERR_W-1:0] errCount
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    frameInfo_t info;
    laneCtrl_t  ctrl;

    fsm_lane_datapath #(
      .SYNC_POS(SYNC_POS)
    ) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .bitValid (bitValid[i]),
      .bitData  (bitData[i]),
      .frameMark(frameMark[i]),
      .ctrl     (ctrl),
      .info     (info)
    );

    fsm_lane_control #(
      .ACQ_FRAMES(ACQ_FRAMES),
      .WINDOW    (WINDOW),
      .LOSS_ERRS (LOSS_ERRS),
      .ERR_W     (ERR_W)
    ) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .info    (info),
      .ctrl    (ctrl),
      .synced  (syncOk[i]),
      .errCount(errCount[i*ERR_W +: ERR_W])
    );
  end

endmodule

// File: rtl/frame_sync_monitor_checker.sv
module frame_sync_monitor_checker #(
  parameter int LANES     = 3,
  parameter int LOSS_ERRS = 3,
  parameter int ERR_W     = $clog2(LOSS_ERRS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [LANES-1:0]       frameMark,
  input logic [LANES-1:0]       syncOk,
  input logic [LANES*ERR_W-1:0] errCount
);
  localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(LOSS_ERRS - 1);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (syncOk == '0 && errCount == '0));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_rise_on_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(syncOk[i]) |-> $past(frameMark[i]));

    assert_err_only_on_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !frameMark[i] |=> $stable(errCount[i*ERR_W +: ERR_W]));

    assert_drop_after_last_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(syncOk[i]) |-> ($past(frameMark[i]) &&
                            $past(errCount[i*ERR_W +: ERR_W]) == ERR_LAST));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      errCount[i*ERR_W +: ERR_W] <= ERR_LAST);

    assert_err_zero_unsynced_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !syncOk[i] |-> errCount[i*ERR_W +: ERR_W] == '0);
  end

endmodule

bind frame_sync_monitor frame_sync_monitor_checker #(
  .LANES    (LANES),
  .LOSS_ERRS(LOSS_ERRS),
  .ERR_W    (ERR_W)
) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .frameMark(frameMark),
  .syncOk   (syncOk),
  .errCount (errCount)
);

// File: tb/frame_sync_monitor_bench.sv
`timescale 1ns/1ps
module frame_sync_monitor_bench;
  localparam int LANES = 3;
  localparam int SPOS  = 2;
  localparam int EW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0] bitValid = '0;
  logic [LANES-1:0] bitData = '0;
  logic [LANES-1:0] frameMark = '0;
  logic [LANES-1:0] syncOk;
  logic [LANES*EW-1:0] errCount;

  int testsRun = 0;
  int testsFailed = 0;
  logic [LANES-1:0] lastBit = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  frame_sync_monitor u_frame_sync_monitor (
    .clk(clk), .rst_n(rst_n), .bitValid(bitValid), .bitData(bitData),
    .frameMark(frameMark), .syncOk(syncOk), .errCount(errCount)
  );

  task automatic check(input string req, input int lane, input logic expSync, input int expErr);
    int actErr;
    actErr = int'(errCount[lane*EW +: EW]);
    testsRun++;
    if (syncOk[lane] !== expSync || actErr != expErr) begin
      testsFailed++;
      $display("FAIL %s lane%0d: sync=%0b err=%0d expected sync=%0b err=%0d",
               req, lane, syncOk[lane], actErr, expSync, expErr);
    end
  endtask

  // one frame on the lanes in en; bad lanes repeat their last sync bit
  task automatic sendFrame(input logic [LANES-1:0] en, input logic [LANES-1:0] bad,
                           input int nbits, input bit bitOnMark);
    logic [LANES-1:0] sb;
    sb = bad ? (lastBit & bad) | (~lastBit & ~bad) : ~lastBit;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      bitValid = en;
      bitData  = (i == SPOS) ? sb : ~sb;
    end
    @(negedge clk);
    bitValid  = bitOnMark ? en : '0;
    bitData   = ~sb;
    frameMark = en;
    @(negedge clk);
    bitValid  = '0;
    frameMark = '0;
    if (nbits > SPOS) lastBit = (lastBit & ~en) | (sb & en);
  endtask

  task automatic good(input int lane, input int n);
    for (int k = 0; k < n; k++) sendFrame(LANES'(1) << lane, '0, 4, 1'b0);
  endtask

  task automatic bad(input int lane);
    sendFrame(LANES'(1) << lane, LANES'(1) << lane, 4, 1'b0);
  endtask

  task automatic t_reset();
    for (int l = 0; l < LANES; l++) check("R1 reset", l, 1'b0, 0);
  endtask

  task automatic t_acquire();
    good(0, 4);
    check("R3 one frame short", 0, 1'b0, 0);
    good(0, 1);
    check("R3 acquired", 0, 1'b1, 0);
    check("R10 lane1 untouched", 1, 1'b0, 0);
    check("R10 lane2 untouched", 2, 1'b0, 0);
  endtask

  task automatic t_run_restart();
    good(1, 3);
    bad(1);
    good(1, 3);
    check("R4 run restarted", 1, 1'b0, 0);
    good(1, 1);
    check("R4 acquired after new ref", 1, 1'b1, 0);
  endtask

  task automatic t_position();
    good(0, 1);
    check("R2 sync bit at index", 0, 1'b1, 0);
    sendFrame(3'b001, '0, 4, 1'b1);
    good(0, 1);
    check("R2 bit on frameMark dropped", 0, 1'b1, 0);
  endtask

  task automatic t_short();
    sendFrame(3'b001, 3'b001, 2, 1'b0);
    check("R5 short frame ignored", 0, 1'b1, 0);
    good(0, 1);
    check("R5 reference kept", 0, 1'b1, 0);
  endtask

  task automatic t_lazy_window();
    bad(0);
    check("R6 first error", 0, 1'b1, 1);
    good(0, 1);
    bad(0);
    check("R6 second error frame3", 0, 1'b1, 2);
    good(0, 7);
    check("R8 count held past window", 0, 1'b1, 2);
    bad(0);
    check("R8 restart at frame11", 0, 1'b1, 1);
    good(0, 1);
    bad(0);
    check("R6 second error new window", 0, 1'b1, 2);
    bad(0);
    check("R7 third error drops sync", 0, 1'b0, 0);
    check("R10 lane1 unaffected", 1, 1'b1, 0);
  endtask

  task automatic t_relock();
    good(0, 4);
    check("R9 no relock yet", 0, 1'b0, 0);
    good(0, 1);
    check("R9 relocked", 0, 1'b1, 0);
  endtask

  task automatic t_edge_frame10();
    bad(0);
    bad(0);
    check("R6 two errors", 0, 1'b1, 2);
    good(0, 7);
    check("R7 still synced frame9", 0, 1'b1, 2);
    bad(0);
    check("R7 third error at frame10", 0, 1'b0, 0);
    check("R11 count zero unsynced", 0, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_acquire();
    t_run_restart();
    t_position();
    t_short();
    t_lazy_window();
    t_relock();
    t_edge_frame10();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule